// File: doc/BRIEF.md
# Management ROM Host Access Gate

This block sits between a host bus port and the management controller's flash ROM and decides, request by request, whether a host-side read or write may reach the ROM. After reset the host window is open so that the host can fetch the option ROM image. Management firmware then issues a one-way close command, and from then on every host access is refused. Only a full reset reopens the window.

The window stays open in two cases. The first is a safe-mode override input, which a service jumper drives. The second is management firmware that never reports that it is running. In that case the host can reflash a corrupted ROM directly. A reserved boot-block address range has its own write gate, and writes into it succeed only while the override is asserted. The flash itself is modelled as a plain word memory. Its contents survive reset, and its erase and program algorithms are not modelled.

Each host request is a single-cycle strobe. It gets exactly one response one cycle later: an acknowledge pulse with read data and an error flag.

Top module: `romAccessGuard`

## Requirements
- R1: After reset the window is open. A read of address `a` returns the preloaded word `16'hC300 | a` with the error flag low, and `hostAck` pulses exactly one cycle after the request cycle.
- R2: A `mgmtClose` pulse, given while the override is low and firmware has not timed out, closes the window. Every later read is acknowledged with `hostErr` = 1 and `hostRdata` all ones.
- R3: While `safeMode` is high, `mgmtClose` is ignored. The window remains open after the override is later released.
- R4: If no `mgmtAlive` pulse arrives within `ALIVE_TIMEOUT` cycles after reset, the firmware is treated as failed. Every `mgmtClose` is then ignored until the next reset.
- R5: A write inside the boot-block range is performed only while `safeMode` is high. Otherwise it is dropped with `hostErr` = 1 and the stored word is unchanged, even when the window is open.
- R6: While the window is closed, host writes are discarded with `hostErr` = 1, and the ROM content is unchanged when it is read after the next reset.
- R7: A closed window stays closed whatever host traffic follows. Only a reset reopens it.
- R8: With the window open, a write outside the boot-block range stores the data, answers with `hostErr` = 0, and a later read returns the written value.
- R9: The boot-block range is inclusive, `BOOT_BASE <= addr <= BOOT_LIMIT` (defaults 0x38 to 0x3F). A write at `BOOT_BASE - 1` is an ordinary write, and a write at `BOOT_LIMIT` is gated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host request strobe, one cycle per access |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | AW | Host word address |
| hostWdata | input | DW | Host write data |
| hostAck | output | 1 | Response valid, one cycle after the request |
| hostRdata | output | DW | Read data, all ones on a refused access |
| hostErr | output | 1 | Access refused or dropped |
| mgmtClose | input | 1 | Firmware close command pulse |
| mgmtAlive | input | 1 | Firmware-alive pulse |
| safeMode | input | 1 | Safe-mode override |

## Verification
The gate's hidden state is the window state and the alive timer. A wrong state shows up on the very next host response: a refused access turns into real data, or real data turns into all ones with the error flag set. A premature or missing timeout only becomes visible when a close command arrives after the timeout point, so the bench lets the timer run out before closing. Dropped writes are checked by reading the word back, after a reset where needed, because that is the only way the ROM content is visible at the ports.

// File: rtl/romGuardPkg.sv
package romGuardPkg;

  // Per-request decision handed from control to datapath
  typedef struct packed {
    logic rdEn;   // perform a ROM read
    logic wrEn;   // perform a ROM write
    logic deny;   // refuse: all-ones data, error flag
  } gateStrobe_t;

  typedef enum logic [1:0] {
    GATE_WAIT   = 2'd0,  // open, waiting for firmware-alive
    GATE_ALIVE  = 2'd1,  // open, firmware is running
    GATE_FAILED = 2'd2,  // open for good, firmware timed out
    GATE_CLOSED = 2'd3   // closed until reset
  } gateState_t;

endpackage

// File: rtl/romGuardCtrl.sv
module romGuardCtrl
  import romGuardPkg::*;
#(
  parameter int AW            = 6,
  parameter int ALIVE_TIMEOUT = 32,
  parameter int BOOT_BASE     = 56,
  parameter int BOOT_LIMIT    = 63
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic          mgmtClose,
  input  logic          mgmtAlive,
  input  logic          safeMode,
  output gateStrobe_t   strobe
);

  localparam int CW = $clog2(ALIVE_TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_WAIT = CW'(ALIVE_TIMEOUT - 1);
  localparam logic [AW-1:0] BASE_A    = AW'(BOOT_BASE);
  localparam logic [AW-1:0] LIMIT_A   = AW'(BOOT_LIMIT);

  gateState_t    state, stateNext;
  logic [CW-1:0] waitCnt;
  logic          pathOpen;
  logic          inBoot;
  logic          closeOk;

  assign pathOpen = (state != GATE_CLOSED);
  assign inBoot   = (hostAddr >= BASE_A) && (hostAddr <= LIMIT_A);
  assign closeOk  = mgmtClose && !safeMode &&
                    ((state == GATE_WAIT) || (state == GATE_ALIVE));

  // Window state machine
  always_comb begin
    stateNext = state;
    unique case (state)
      GATE_WAIT: begin
        if (closeOk)                 stateNext = GATE_CLOSED;
        else if (mgmtAlive)          stateNext = GATE_ALIVE;
        else if (waitCnt == LAST_WAIT) stateNext = GATE_FAILED;
      end
      GATE_ALIVE: begin
        if (closeOk) stateNext = GATE_CLOSED;
      end
      GATE_FAILED: stateNext = GATE_FAILED;
      GATE_CLOSED: stateNext = GATE_CLOSED;
      default:     stateNext = GATE_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= GATE_WAIT;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == GATE_WAIT && waitCnt != LAST_WAIT)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  // Per-request decision
  always_comb begin
    strobe = '0;
    if (hostReq) begin
      if (!pathOpen)                  strobe.deny = 1'b1;
      else if (!hostWe)               strobe.rdEn = 1'b1;
      else if (inBoot && !safeMode)   strobe.deny = 1'b1;
      else                            strobe.wrEn = 1'b1;
    end
  end

  AST_CLOSE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == GATE_CLOSED) |-> ($past(mgmtClose) && !$past(safeMode))); // R2

  AST_OVERRIDE_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (safeMode && state != GATE_CLOSED) |=> (state != GATE_CLOSED)); // R3

  AST_FAILED_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_FAILED) |=> (state == GATE_FAILED)); // R4

  AST_CLOSED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_CLOSED) |=> (state == GATE_CLOSED)); // R7

  AST_BOOT_WRITE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && inBoot) |-> safeMode); // R5

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdEn, strobe.wrEn, strobe.deny})); // R1

endmodule

// File: rtl/romGuardData.sv
module romGuardData
  import romGuardPkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter logic [15:0] INIT_TAG = 16'hC300
) (
  input  logic          clk,
  input  logic          rstN,
  input  gateStrobe_t   strobe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  output logic          hostAck,
  output logic [DW-1:0] hostRdata,
  output logic          hostErr
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] romMem [DEPTH];

  // Flash model: contents are preloaded once and survive reset
  initial begin
    for (int i = 0; i < DEPTH; i++)
      romMem[i] = DW'(INIT_TAG) | DW'(i);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn)
      romMem[hostAddr] <= hostWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostAck   <= 1'b0;
      hostRdata <= '0;
      hostErr   <= 1'b0;
    end else begin
      hostAck <= strobe.rdEn | strobe.wrEn | strobe.deny;
      if (strobe.deny) begin
        hostRdata <= '1;
        hostErr   <= 1'b1;
      end else if (strobe.rdEn) begin
        hostRdata <= romMem[hostAddr];
        hostErr   <= 1'b0;
      end else begin
        hostRdata <= '0;
        hostErr   <= 1'b0;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (romMem[$past(hostAddr)] == $past(hostWdata))); // R8

  AST_DENY_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deny |=> (hostAck && hostErr && (&hostRdata))); // R2

endmodule

// File: rtl/romAccessGuard.sv
module romAccessGuard
  import romGuardPkg::*;
#(
  parameter int AW            = 6,
  parameter int DW            = 16,
  parameter int ALIVE_TIMEOUT = 32,
  parameter int BOOT_BASE     = 56,
  parameter int BOOT_LIMIT    = 63,
  parameter logic [15:0] INIT_TAG = 16'hC300
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  output logic          hostAck,
  output logic [DW-1:0] hostRdata,
  output logic          hostErr,
  input  logic          mgmtClose,
  input  logic          mgmtAlive,
  input  logic          safeMode
);

  gateStrobe_t strobe;

  romGuardCtrl #(
    .AW(AW), .ALIVE_TIMEOUT(ALIVE_TIMEOUT),
    .BOOT_BASE(BOOT_BASE), .BOOT_LIMIT(BOOT_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .mgmtClose(mgmtClose), .mgmtAlive(mgmtAlive), .safeMode(safeMode),
    .strobe(strobe)
  );

  romGuardData #(
    .AW(AW), .DW(DW), .INIT_TAG(INIT_TAG)
  ) i_data (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostAck(hostAck), .hostRdata(hostRdata), .hostErr(hostErr)
  );

endmodule

// File: tb/test_romAccessGuard.sv
module test_romAccessGuard;

  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic          hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic          hostAck;
  logic [DW-1:0] hostRdata;
  logic          hostErr;
  logic          mgmtClose = 1'b0;
  logic          mgmtAlive = 1'b0;
  logic          safeMode = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  romAccessGuard i_romAccessGuard (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .hostErr(hostErr), .mgmtClose(mgmtClose), .mgmtAlive(mgmtAlive),
    .safeMode(safeMode)
  );

  function automatic logic [DW-1:0] initWord(input int a);
    return 16'hC300 | DW'(a);
  endfunction

  // Monitor: pops an expected item for every acknowledge
  always @(negedge clk) begin
    if (rstN && hostAck) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected ack data=%h err=%b expected no response", hostRdata, hostErr);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (hostRdata !== e.data || hostErr !== e.err) begin
          errors++;
          $display("FAIL %s actual data=%h err=%b expected data=%h err=%b",
                   e.tag, hostRdata, hostErr, e.data, e.err);
        end
      end
    end
  end

  // Driver: one request cycle, then one idle cycle
  task automatic access(input bit we, input int a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] expData, input bit expErr, input string tag);
    expItem_t e;
    e.data = expData; e.err = expErr; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = AW'(a); hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0; hostWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (hostAck !== 1'b0 || hostErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset ack=%b err=%b expected 0 0", hostAck, hostErr);
    end
    rstN = 1'b1;
  endtask

  task automatic drainCheck();
    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses actual %0d pending expected 0", expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    fork
      begin
        doReset();
        pulse(mgmtAlive);
        // R1: open after reset, preloaded contents
        access(0, 0,  '0, initWord(0), 0, "R1");
        access(0, 5,  '0, initWord(5), 0, "R1");
        // R8: ordinary write then read back
        access(1, 3,  16'h1234, '0, 0, "R8");
        access(0, 3,  '0, 16'h1234, 0, "R8");
        // R5: boot write without override is dropped
        access(1, 56, 16'hDEAD, 16'hFFFF, 1, "R5");
        access(0, 56, '0, initWord(56), 0, "R5");
        // R9: range edges
        access(1, 55, 16'h7777, '0, 0, "R9");
        access(0, 55, '0, 16'h7777, 0, "R9");
        access(1, 63, 16'h8888, 16'hFFFF, 1, "R9");
        access(0, 63, '0, initWord(63), 0, "R9");
        // R2: close
        pulse(mgmtClose);
        access(0, 0,  '0, 16'hFFFF, 1, "R2");
        // R6: closed write discarded
        access(1, 3,  16'hBEEF, 16'hFFFF, 1, "R6");
        // R7: stays closed after traffic
        access(0, 3,  '0, 16'hFFFF, 1, "R7");
        access(0, 10, '0, 16'hFFFF, 1, "R7");
        drainCheck();

        // R7/R6: reset reopens, discarded write left no trace
        doReset();
        pulse(mgmtAlive);
        access(0, 3,  '0, 16'h1234, 0, "R6");
        access(0, 1,  '0, initWord(1), 0, "R7");

        // R3/R5: safe-mode override
        safeMode = 1'b1;
        access(1, 56, 16'h5A5A, '0, 0, "R5");
        access(0, 56, '0, 16'h5A5A, 0, "R5");
        pulse(mgmtClose);
        access(0, 0,  '0, initWord(0), 0, "R3");
        safeMode = 1'b0;
        access(0, 2,  '0, initWord(2), 0, "R3");
        drainCheck();

        // R4: firmware never reports alive
        doReset();
        repeat (40) @(negedge clk);
        pulse(mgmtClose);
        access(0, 4,  '0, initWord(4), 0, "R4");
        access(1, 7,  16'h4444, '0, 0, "R4");
        access(0, 7,  '0, 16'h4444, 0, "R4");
        drainCheck();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule